// File: doc/BRIEF.md
# Radix-16 Floating-Point Significand Square Root

The block takes the significand and unbiased exponent of a normalized floating-point number and returns its square root. The result is a significand rounded to nearest, ties to even, and the halved exponent. Three formats are supported: half, single and double precision. The work runs through three phases. An initialization cycle makes the exponent even and produces the two leading root bits. A run of iteration cycles follows, each retiring four root bits. A final cycle rounds the result.

Each iteration cycle chains two radix-4 steps. The second digit is chosen speculatively: four copies of the second step, one per possible first digit, run alongside the first step, and the first digit then picks one of them. Digit selection compares the shifted residual exactly against the cost of each digit, so the digits are non-negative (0 to 3). The residual therefore never goes negative and needs no final correction. A nonzero final residual feeds the sticky bit. Latency is fixed for each precision.

Significands are left-aligned on a 53-bit port. The hidden 1 sits in bit 52. Half precision uses bits 52..42 and single precision uses bits 52..29. The exponent is a 12-bit two's complement value.

Top module: `sqrt_r16`

## Requirements
- R1: The result significand on `sig_out` equals sqrt(m), rounded to nearest-even at P bits, where P is 11, 24 or 53. Here m is the input significand value in [1,2), doubled when the exponent is odd. The result is left-aligned with its leading 1 in bit 52, and the bits below the precision are zero.
- R2: `exp_out` equals floor(e/2) for input exponent e, in two's complement.
- R3: `done` rises a fixed number of clock edges after the edge that samples `start`. That number is 5 for `prec` = 2'b00 (half), 8 for 2'b01 (single) and 15 for 2'b10 or 2'b11 (double). `busy` is high in every cycle between these two edges.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle. `sig_out` and `exp_out` keep their values until the next completion.
- R5: A `start` while `busy` is high is ignored. The running operation finishes with its own result and latency, and no extra completion follows.
- R6: Significand input bits below the selected precision have no effect on the result.
- R7: After each iteration, the partial residual R and the partial root Q satisfy 0 <= R <= 2Q. This is the bound kept by exact digit selection.
- R8: After reset, `busy` and `done` are low and `sig_out` and `exp_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| prec | input | 2 | 00 half, 01 single, 1x double |
| sig_in | input | 53 | Left-aligned significand with hidden bit in bit 52 |
| exp_in | input | 12 | Unbiased exponent, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sig_out | output | 53 | Rounded root significand, left-aligned |
| exp_out | output | 12 | Halved exponent |

## Verification
The bench targets odd and negative exponents. A design that skipped the pre-shift or halved toward zero would return a root off by a factor of sqrt(2) or an exponent one too high. Exact squares and values just under 4 probe the sticky path: a sticky bit taken from the root alone, without the residual, would mis-round near ties, and an exact case would show spurious rounding. Stray low bits in half and single operands, and a second start in the middle of a run, expose a missing mask or a re-captured operand. Per-precision latency checks catch an iteration count that is off by one cycle.

// File: rtl/sqrt_r16.sv
module sqrt_r16 #(
  parameter int EXP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       prec,
  input  logic [52:0]      sig_in,
  input  logic [EXP_W-1:0] exp_in,
  output logic             busy,
  output logic             done,
  output logic [52:0]      sig_out,
  output logic [EXP_W-1:0] exp_out
);
  localparam int SW = 53;
  localparam int QW = SW + 1;
  localparam int RW = QW + 6;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_ITER, S_RND} st_t;

  st_t              st;
  logic [1:0]       pr;
  logic [QW-1:0]    rad;
  logic [QW-1:0]    q;
  logic [RW-1:0]    r;
  logic [3:0]       cnt;
  logic [EXP_W-1:0] ex;

  function automatic logic [RW-1:0] cost(input logic [QW-1:0] qq, input logic [1:0] d);
    logic [RW-1:0] q8;
    q8 = RW'(qq) << 3;
    case (d)
      2'd0:    cost = '0;
      2'd1:    cost = q8 + RW'(1);
      2'd2:    cost = (q8 << 1) + RW'(4);
      default: cost = q8 + (q8 << 1) + RW'(9);
    endcase
  endfunction

  function automatic logic [1:0] sel4(input logic [RW-1:0] t, input logic [QW-1:0] qq);
    if (t >= cost(qq, 2'd3))      sel4 = 2'd3;
    else if (t >= cost(qq, 2'd2)) sel4 = 2'd2;
    else if (t >= cost(qq, 2'd1)) sel4 = 2'd1;
    else                          sel4 = 2'd0;
  endfunction

  function automatic logic [3:0] iters(input logic [1:0] p);
    if (p == 2'b00)      iters = 4'd3;
    else if (p == 2'b01) iters = 4'd6;
    else                 iters = 4'd13;
  endfunction

  function automatic logic [SW-1:0] prec_mask(input logic [1:0] p);
    if (p == 2'b00)      prec_mask = {{11{1'b1}}, 42'b0};
    else if (p == 2'b01) prec_mask = {{24{1'b1}}, 29'b0};
    else                 prec_mask = '1;
  endfunction

  // initialization: integer root bit plus first fraction bit
  logic [3:0] it0;
  logic       it0_ge;
  assign it0    = {rad[QW-1:QW-2] - 2'd1, rad[QW-3:QW-4]};
  assign it0_ge = it0 >= 4'd5;

  // iteration: first radix-4 step with four speculative second steps
  logic [RW-1:0] t1;
  logic [1:0]    d1;
  logic [1:0]    d2s [4];
  logic [RW-1:0] r2s [4];

  assign t1 = (r << 4) | RW'(rad[QW-1:QW-4]);
  assign d1 = sel4(t1, q);

  for (genvar c = 0; c < 4; c++) begin : g_spec
    logic [QW-1:0] qc;
    logic [RW-1:0] tc;
    assign qc     = (q << 2) | QW'(c);
    assign tc     = ((t1 - cost(q, 2'(c))) << 4) | RW'(rad[QW-5:QW-8]);
    assign d2s[c] = sel4(tc, qc);
    assign r2s[c] = tc - cost(qc, d2s[c]);
  end

  logic [QW-1:0] q_it;
  logic [RW-1:0] r_it;
  assign q_it = (q << 4) | QW'({d1, d2s[d1]});
  assign r_it = r2s[d1];

  // rounding to nearest even
  logic          rnz;
  logic [10:0]   rh;
  logic [23:0]   rs;
  logic [52:0]   rd;
  logic [SW-1:0] rnd_sig;
  assign rnz = |r;
  assign rh  = q[13:3] + {10'b0, q[2] & (q[3] | q[1] | q[0] | rnz)};
  assign rs  = q[25:2] + {23'b0, q[1] & (q[2] | q[0] | rnz)};
  assign rd  = q[53:1] + {52'b0, q[0] & (q[1] | rnz)};

  always_comb begin
    if (pr == 2'b00)      rnd_sig = {rh, 42'b0};
    else if (pr == 2'b01) rnd_sig = {rs, 29'b0};
    else                  rnd_sig = rd;
  end

  assign busy = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pr      <= '0;
      rad     <= '0;
      q       <= '0;
      r       <= '0;
      cnt     <= '0;
      ex      <= '0;
      done    <= 1'b0;
      sig_out <= '0;
      exp_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pr  <= prec;
          ex  <= EXP_W'($signed(exp_in) >>> 1);
          rad <= exp_in[0] ? {sig_in & prec_mask(prec), 1'b0}
                           : {1'b0, sig_in & prec_mask(prec)};
          st  <= S_INIT;
        end
        S_INIT: begin
          q   <= it0_ge ? QW'(3) : QW'(2);
          r   <= it0_ge ? RW'(it0 - 4'd5) : RW'(it0);
          rad <= rad << 4;
          cnt <= iters(pr) - 4'd1;
          st  <= S_ITER;
        end
        S_ITER: begin
          q   <= q_it;
          r   <= r_it;
          rad <= rad << 8;
          cnt <= cnt - 4'd1;
          if (cnt == 4'd0) st <= S_RND;
        end
        default: begin
          sig_out <= rnd_sig;
          exp_out <= ex;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
      endcase
    end
  end

  AST_RESID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ITER || st == S_RND) |-> (r <= (RW'(q) << 1))); // R7

  AST_ROOT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RND) |-> ((pr == 2'b00) ? (q[13] && q[QW-1:14] == '0) :
                       (pr == 2'b01) ? (q[25] && q[QW-1:26] == '0) : q[53])); // R1

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ex) && $stable(pr))); // R5

endmodule

// File: tb/sqrt_r16_test.sv
module sqrt_r16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  prec = '0;
  logic [52:0] sig_in = '0;
  logic [11:0] exp_in = '0;
  logic        busy, done;
  logic [52:0] sig_out;
  logic [11:0] exp_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  sqrt_r16 uut (.clk(clk), .rst_n(rst_n), .start(start), .prec(prec), .sig_in(sig_in),
                .exp_in(exp_in), .busy(busy), .done(done), .sig_out(sig_out), .exp_out(exp_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] isqrt(input logic [127:0] n);
    logic [127:0] res = '0;
    for (int i = 63; i >= 0; i--) begin
      logic [127:0] t;
      t = res | (128'd1 << i);
      if (t * t <= n) res = t;
    end
    return res;
  endfunction

  function automatic int width_of(input logic [1:0] p);
    return (p == 2'b00) ? 11 : (p == 2'b01) ? 24 : 53;
  endfunction

  function automatic int lat_of(input logic [1:0] p);
    return (p == 2'b00) ? 5 : (p == 2'b01) ? 8 : 15;
  endfunction

  function automatic logic [52:0] exp_sig(input logic [1:0] p, input logic [52:0] s, input logic [11:0] e);
    int pw, sh;
    logic [52:0] sm;
    logic [127:0] x, n, rt, mant, res;
    bit exact, up;
    pw = width_of(p);
    sm = s & ~((53'd1 << (53 - pw)) - 53'd1);
    x = e[0] ? (128'(sm) << 1) : 128'(sm);
    sh = 2 * pw - 52;
    n = (sh >= 0) ? (x << sh) : (x >> (-sh));
    rt = isqrt(n);
    exact = (rt * rt == n);
    mant = rt >> 1;
    up = rt[0] && (!exact || mant[0]);
    res = mant + 128'(up);
    return 53'(res << (53 - pw));
  endfunction

  function automatic logic [11:0] exp_exp(input logic [11:0] e);
    int v;
    v = $signed(e);
    v = (v - int'(e[0])) / 2;
    return 12'(v);
  endfunction

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic do_op(input logic [1:0] p, input logic [52:0] s, input logic [11:0] e, input string tag);
    int cyc;
    bit busy_ok;
    @(negedge clk);
    start = 1'b1; prec = p; sig_in = s; exp_in = e;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    busy_ok = 1;
    while (!done && cyc < 100) begin
      if (!busy) busy_ok = 0;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == lat_of(p) + 1, {"R3 latency ", tag}, 64'(cyc - 1), 64'(lat_of(p)));
    chk(busy_ok, {"R3 busy during run ", tag}, 64'(busy_ok), 64'd1);
    chk(sig_out == exp_sig(p, s, e), {"R1 significand ", tag}, 64'(sig_out), 64'(exp_sig(p, s, e)));
    chk(exp_out == exp_exp(e), {"R2 exponent ", tag}, 64'(exp_out), 64'(exp_exp(e)));
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R8 reset flags", {62'b0, busy, done}, 64'd0);
    chk(sig_out == '0 && exp_out == '0, "R8 reset outputs", 64'(sig_out) ^ 64'(exp_out), 64'd0);
  endtask

  task automatic t_directed();
    do_op(2'b00, {1'b1, 52'b0}, 12'd0, "half one");
    do_op(2'b00, {1'b1, 52'b0}, 12'd1, "half two odd exp");
    do_op(2'b01, {3'b100, 1'b1, 49'b0}, 12'd1, "single exact 2.25");
    do_op(2'b10, {53{1'b1}}, 12'd1, "double near four");
    do_op(2'b10, {1'b1, 52'h5555555555555}, 12'hFFD, "double neg odd exp");
    do_op(2'b11, {2'b11, 51'b0}, 12'hFF8, "double code 11");
    do_op(2'b01, {24'hFFFFFF, 29'b0}, 12'd7, "single all ones");
  endtask

  task automatic t_mask();
    do_op(2'b00, {11'b10110011101, 42'h3FFFFFFFFFF}, 12'd3, "R6 half stray bits");
    do_op(2'b01, {24'hC0FFEE, 29'h1ABCDEF0}, 12'hFFE, "R6 single stray bits");
    chk(sig_out[28:0] == '0, "R6 single low zero", 64'(sig_out[28:0]), 64'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 150; i++) begin
      logic [63:0] a, b;
      a = next_rand();
      b = next_rand();
      do_op(b[1:0], {1'b1, a[51:0]}, {{4{b[15]}}, b[15:8]}, "random");
    end
  endtask

  task automatic t_hold();
    logic [52:0] s0;
    logic [11:0] e0;
    do_op(2'b01, {1'b1, 52'hABCDE12345678}, 12'd9, "R4 base");
    s0 = sig_out;
    e0 = exp_out;
    chk(!busy, "R4 busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done, "R4 done one cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk(sig_out == s0 && exp_out == e0, "R4 outputs held", 64'(sig_out), 64'(s0));
  endtask

  task automatic t_busy_start();
    int cyc;
    int extra;
    logic [52:0] sa;
    sa = {1'b1, 52'h123456789ABCD};
    @(negedge clk);
    start = 1'b1; prec = 2'b10; sig_in = sa; exp_in = 12'd5;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    repeat (3) begin @(negedge clk); cyc++; end
    start = 1'b1; prec = 2'b00; sig_in = {53{1'b1}}; exp_in = 12'd100;
    @(negedge clk);
    cyc++;
    start = 1'b0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == 16, "R5 latency of first op", 64'(cyc - 1), 64'd15);
    chk(sig_out == exp_sig(2'b10, sa, 12'd5), "R5 result of first op", 64'(sig_out), 64'(exp_sig(2'b10, sa, 12'd5)));
    chk(exp_out == exp_exp(12'd5), "R5 exponent of first op", 64'(exp_out), 64'(exp_exp(12'd5)));
    extra = 0;
    repeat (20) begin @(negedge clk); if (done || busy) extra++; end
    chk(extra == 0, "R5 no second completion", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_mask();
    t_hold();
    t_busy_start();
    t_random();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule